// File: doc/BRIEF.md
# Programmable PRBS Bit-Error Checker

This block checks a received parallel data word against a pseudo-random binary sequence that it predicts locally. The feedback equation is not fixed: a 32-bit tap mask selects which of the last 32 received bits are combined by XOR to form the next bit. Any linear-feedback sequence of length up to 32 can be checked by changing this mask while the block runs, with no rebuild.

Software first puts the block in a loading mode. In that mode the predictor fills its history from the bits that actually arrive, so it locks to the stream without knowing the seed. A run mode then compares each incoming word with the predicted word and adds to two saturating counters: bits checked and bits in error. A hold mode freezes both counters for readout. The predictor keeps stepping in hold mode, so a later run continues in lock. Each counter is read as a low half and a high half through one select input.

Top module: `prbs_err_checker`

## Requirements
- R1: While `rst` is high at a rising clock edge, both counters clear to zero and the predictor history clears. After reset, all four read selections return zero.
- R2: With `mode` = 0 (clear) at an edge, both counters become zero. The predictor history is loaded from the received bits of that word.
- R3: With `mode` = 1 (load) at an edge, the predictor history is loaded from the received bits. Both counters keep their values.
- R4: With `mode` = 2 (run) at an edge, the bit counter grows by DW, the word width.
- R5: With `mode` = 2 (run) at an edge, the error counter grows by the number of positions where `rx_word` differs from the predicted word. Bit 0 of a word is the earliest bit. The predicted bit is the XOR of the history bits h[k] for which `tap_mask[k]` = 1, where h[0] is the most recent bit. After each bit, the history shifts up by one, with the new bit entering at h[0]. Mask 0x100002 gives x^21 + x^2 + 1, and mask 0x60 gives x^7 + x^6 + 1.
- R6: With `mode` = 3 (hold) at an edge, both counters keep their values whatever `rx_word` carries.
- R7: `rd_data` returns, by `rd_sel`: 0 = error count low half, 1 = error count high half, 2 = bit count low half, 3 = bit count high half. Each half is CNT_W/2 bits.
- R8: Neither counter wraps. An addition that would pass 2^CNT_W - 1 leaves the counter at 2^CNT_W - 1.
- R9: In hold and run modes, the predictor steps on its own predicted bits, not on the received ones. A stream that stays correct across a hold period adds no errors when run mode resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 0 clear+load, 1 load, 2 run, 3 hold |
| tap_mask | input | 32 | Feedback tap selection over the history |
| rx_word | input | DW | Received word, bit 0 earliest |
| rd_sel | input | 2 | Readout half selection |
| rd_data | output | CNT_W/2 | Selected counter half |

## Verification
The bench builds the block with DW = 16 and CNT_W = 16, so each readout half is 8 bits. With these values both counters reach their ceiling of 65535 after about 4100 cycles of fully inverted data, which puts the saturation rule within reach of a short run. The high halves also carry, so both halves of each counter are compared. The bench uses two tap masks, a 21-bit sequence and a 7-bit one, and checks error injection, resynchronisation after garbage, and lock that is kept across hold.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    localparam int TAP_W = 32;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_RUN   = 2'd2,
        MODE_HOLD  = 2'd3
    } chk_mode_e;

    typedef struct packed {
        logic clr;    // zero the counters
        logic load;   // history follows received bits
        logic count;  // accumulate
    } chk_ctrl_t;

    function automatic chk_ctrl_t decode_mode(input logic [1:0] m);
        chk_ctrl_t c;
        c.clr   = (m == MODE_CLEAR);
        c.load  = (m == MODE_CLEAR) || (m == MODE_LOAD);
        c.count = (m == MODE_RUN);
        return c;
    endfunction

    function automatic logic tap_parity(input logic [TAP_W-1:0] hist,
                                        input logic [TAP_W-1:0] mask);
        return ^(hist & mask);
    endfunction

endpackage

// File: rtl/prbs_predictor.sv
module prbs_predictor
    import prbs_chk_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TAP_W-1:0] tap_mask,
    input  logic [DW-1:0]    rx_word,
    output logic [DW-1:0]    pred_word
);

    logic [TAP_W-1:0] hist_q;
    logic [TAP_W-1:0] hist_nx;

    always_comb begin
        logic [TAP_W-1:0] h;
        logic             p;
        h = hist_q;
        pred_word = '0;
        for (int i = 0; i < DW; i++) begin
            p = tap_parity(h, tap_mask);
            pred_word[i] = p;
            h = {h[TAP_W-2:0], (load ? rx_word[i] : p)};
        end
        hist_nx = h;
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_nx;
    end

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W     = 64,
    parameter int INC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     cnt
);

    logic [W:0] sum;

    always_comb sum = {1'b0, cnt} + (W+1)'(inc);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (en)     cnt <= sum[W] ? {W{1'b1}} : sum[W-1:0];
    end

    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr && !en) |=> $stable(cnt));

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt >= $past(cnt)));

endmodule

// File: rtl/prbs_err_checker.sv
module prbs_err_checker
    import prbs_chk_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CNT_W = 64,
    localparam int HALF_W = CNT_W / 2,
    localparam int INC_W  = $clog2(DW + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic [TAP_W-1:0]  tap_mask,
    input  logic [DW-1:0]     rx_word,
    input  logic [1:0]        rd_sel,
    output logic [HALF_W-1:0] rd_data
);

    chk_ctrl_t         ctrl;
    logic [DW-1:0]     pred_word;
    logic [INC_W-1:0]  err_inc;
    logic [CNT_W-1:0]  err_cnt;
    logic [CNT_W-1:0]  tot_cnt;

    always_comb ctrl = decode_mode(mode);

    prbs_predictor #(.DW(DW)) pred_i (
        .clk       (clk),
        .rst       (rst),
        .load      (ctrl.load),
        .tap_mask  (tap_mask),
        .rx_word   (rx_word),
        .pred_word (pred_word)
    );

    always_comb begin
        logic [DW-1:0] diff;
        diff = rx_word ^ pred_word;
        err_inc = '0;
        for (int i = 0; i < DW; i++) err_inc = err_inc + INC_W'(diff[i]);
    end

    sat_counter #(.W(CNT_W), .INC_W(INC_W)) err_ctr_i (
        .clk (clk), .rst (rst), .clr (ctrl.clr), .en (ctrl.count),
        .inc (err_inc), .cnt (err_cnt)
    );

    sat_counter #(.W(CNT_W), .INC_W(INC_W)) tot_ctr_i (
        .clk (clk), .rst (rst), .clr (ctrl.clr), .en (ctrl.count),
        .inc (INC_W'(DW)), .cnt (tot_cnt)
    );

    always_comb begin
        case (rd_sel)
            2'd0:    rd_data = err_cnt[HALF_W-1:0];
            2'd1:    rd_data = err_cnt[CNT_W-1:HALF_W];
            2'd2:    rd_data = tot_cnt[HALF_W-1:0];
            default: rd_data = tot_cnt[CNT_W-1:HALF_W];
        endcase
    end

    p_tot_step_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.count && tot_cnt <= ({CNT_W{1'b1}} - CNT_W'(DW)))
        |=> (tot_cnt == $past(tot_cnt) + CNT_W'(DW)));

    p_err_bound_r5: assert property (@(posedge clk) disable iff (rst)
        err_cnt <= tot_cnt);

    p_load_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOAD) |=> ($stable(err_cnt) && $stable(tot_cnt)));

endmodule

// File: tb/prbs_err_checker_tb_top.sv
module prbs_err_checker_tb_top;

    localparam int DW     = 16;
    localparam int CNT_W  = 16;
    localparam int HALF_W = CNT_W / 2;
    localparam longint MAXV = (64'd1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        mode_i = 2'd3;
    logic [31:0]       mask_i = 32'h0010_0002;
    logic [DW-1:0]     rx_i = '0;
    logic [1:0]        sel_i = '0;
    logic [HALF_W-1:0] rd_o;

    int checks = 0;
    int fails  = 0;
    int sel_ctr = 0;
    bit done = 0;

    // behavioural reference state
    bit     gen_q[$];   // stream generator history, index 0 newest
    bit     mdl_q[$];   // model predictor history, index 0 newest
    longint m_err = 0;
    longint m_tot = 0;

    always #10 clk = ~clk;   // 50 MHz

    prbs_err_checker #(.DW(DW), .CNT_W(CNT_W)) dut_i (
        .clk (clk), .rst (rst), .mode (mode_i), .tap_mask (mask_i),
        .rx_word (rx_i), .rd_sel (sel_i), .rd_data (rd_o)
    );

    function automatic bit qparity(ref bit q[$], input logic [31:0] m);
        bit r = 0;
        for (int k = 0; k < 32; k++)
            if (m[k] && k < q.size()) r ^= q[k];
        return r;
    endfunction

    task automatic push_bit(ref bit q[$], input bit b);
        q.push_front(b);
        if (q.size() > 32) void'(q.pop_back());
    endtask

    task automatic gen_word(output logic [DW-1:0] w);
        for (int i = 0; i < DW; i++) begin
            bit b;
            b = qparity(gen_q, mask_i);
            w[i] = b;
            push_bit(gen_q, b);
        end
    endtask

    task automatic seed_gen(input logic [31:0] s);
        gen_q.delete();
        for (int i = 0; i < 32; i++) gen_q.push_back(s[i]);
    endtask

    function automatic longint sat(input longint v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    task automatic model_step(input logic [1:0] m, input logic [DW-1:0] d);
        int e = 0;
        for (int i = 0; i < DW; i++) begin
            bit p;
            p = qparity(mdl_q, mask_i);
            if (m == 2'd2 && p != d[i]) e++;
            push_bit(mdl_q, (m < 2'd2) ? d[i] : p);
        end
        if (m == 2'd0) begin
            m_err = 0; m_tot = 0;
        end else if (m == 2'd2) begin
            m_err = sat(m_err + e);
            m_tot = sat(m_tot + DW);
        end
    endtask

    // one clock: drive at negedge, model after posedge, compare at negedge (R7 readout)
    task automatic cyc(input logic [1:0] m, input logic [DW-1:0] d, input string tag);
        logic [HALF_W-1:0] exp_v;
        logic [1:0] s;
        s = 2'(sel_ctr);
        mode_i = m; rx_i = d; sel_i = s;
        @(posedge clk);
        model_step(m, d);
        @(negedge clk);
        case (s)
            2'd0: exp_v = m_err[HALF_W-1:0];
            2'd1: exp_v = m_err[CNT_W-1:HALF_W];
            2'd2: exp_v = m_tot[HALF_W-1:0];
            default: exp_v = m_tot[CNT_W-1:HALF_W];
        endcase
        checks++;
        if (rd_o !== exp_v) begin
            fails++;
            $display("FAIL %s sel=%0d actual=%0h expected=%0h", tag, s, rd_o, exp_v);
        end
        sel_ctr++;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin : main
        logic [DW-1:0] w;
        for (int i = 0; i < 32; i++) mdl_q.push_back(1'b0);
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state on all four halves
        for (int i = 0; i < 4; i++) cyc(2'd3, 16'hFFFF, "R1");

        // R2: clear and synchronise on the 21-bit sequence
        mask_i = 32'h0010_0002;
        seed_gen(32'h1234_ABCD);
        for (int i = 0; i < 2; i++) begin gen_word(w); cyc(2'd0, w, "R2"); end
        // R4 R5: clean run
        for (int i = 0; i < 40; i++) begin gen_word(w); cyc(2'd2, w, "R4 R5 clean"); end
        // R5: injected errors
        gen_word(w); cyc(2'd2, w ^ 16'h0109, "R5 three flips");
        gen_word(w); cyc(2'd2, w ^ 16'hFFFF, "R5 full flip");
        for (int i = 0; i < 8; i++) begin gen_word(w); cyc(2'd2, w, "R5 after flips"); end

        // R6: hold ignores garbage; R9: lock kept across hold
        for (int i = 0; i < 10; i++) begin gen_word(w); cyc(2'd3, w ^ 16'h5A5A, "R6"); end
        for (int i = 0; i < 10; i++) begin gen_word(w); cyc(2'd2, w, "R9"); end

        // R3: resync through load mode after garbage, counts kept
        for (int i = 0; i < 4; i++) cyc(2'd1, 16'h3C3C ^ 16'(i), "R3 garbage");
        for (int i = 0; i < 2; i++) begin gen_word(w); cyc(2'd1, w, "R3 load"); end
        for (int i = 0; i < 12; i++) begin gen_word(w); cyc(2'd2, w, "R3 R5 relock"); end

        // R2: clear again, then R5 with a 7-bit sequence mask
        mask_i = 32'h0000_0060;
        seed_gen(32'h0000_0055);
        gen_word(w); cyc(2'd0, w, "R2 clear");
        for (int i = 0; i < 20; i++) begin gen_word(w); cyc(2'd2, w, "R5 mask7"); end
        gen_word(w); cyc(2'd2, w ^ 16'h8000, "R5 mask7 flip");

        // R8: saturation of both counters with inverted data
        for (int i = 0; i < 4110; i++) begin gen_word(w); cyc(2'd2, ~w, "R8"); end
        for (int i = 0; i < 4; i++) cyc(2'd3, 16'h0, "R8 R6 held at max");

        done = 1;
        finish_run();
    end

endmodule